// File: doc/BRIEF.md
# Block-Transfer Host Register Port

This block is the host-facing side of a block-transfer style management controller mailbox. A host sees three byte-wide registers selected by a two-bit address: a control and status byte, a data port and an interrupt mask byte. Bytes the host writes to the data port fill an inbound message buffer. Bytes it reads from the data port drain an outbound message buffer that the controller has loaded.

The control byte mixes several write semantics in one register. Writing a one to a bit can clear a buffer pointer, clear an attention flag, invert the host-busy flag, or mark the controller busy and launch processing. When processing is launched, the block raises a one-cycle request pulse toward the controller. The controller reads the inbound message through a random-access read port and sees the inbound length. It loads a reply through a write port and then commits it, which publishes the reply length and raises the reply attention flag. Message interpretation and interrupt generation belong to neighbouring logic.

Top module: `bt_host_port`

## Requirements
- R1: After reset, the control byte reads 0x00, the mask byte reads 0x00, the data port reads 0xFF, `in_len` is 0 and `msg_req` is low.
- R2: Offsets are decoded from `host_addr`: 0 is control, 1 is data, 2 is mask. Offset 3 always reads 0xFF, and a write to offset 3 changes neither the control byte nor the mask byte.
- R3: Writing a control byte with bit 2 set makes bit 7 (controller busy) read 1 and drives `msg_req` high for exactly one cycle. Both changes appear after the clock edge that accepts the write.
- R4: Writing 1 to control bit 3 clears the reply attention flag, and writing 1 to bit 4 clears the system-software attention flag. Writing 0 to either leaves it unchanged. If a controller set of the same flag happens in the same cycle, the set wins.
- R5: Writing 1 to control bit 6 inverts the host-busy flag. Writing 0 to it leaves the flag unchanged.
- R6: Writing 1 to control bit 0 sets the inbound length to 0. Writing 1 to control bit 1 returns the outbound read position to the first byte.
- R7: A data-port write stores the byte at index `in_len` only while `in_len` is below DEPTH (default 64). Every data-port write increments `in_len`, which saturates at 2^CNT_W-1 (255 by default). Bytes beyond DEPTH are discarded and the stored bytes are left unchanged.
- R8: Data-port reads return the outbound bytes in index order. After the last byte has been read, both the position and the length return to 0. A data-port read with nothing pending returns 0xFF.
- R9: A pulse on `ctl_out_commit` publishes `ctl_out_len` as the outbound length, clamped to DEPTH. It also resets the read position, sets control bit 3 and clears control bit 7. If a bit-2 control write happens in the same cycle, bit 7 stays set.
- R10: A pulse on `ctl_sms_set` sets control bit 4.
- R11: The mask byte is a plain read/write register that holds the full byte last written to offset 2.
- R12: Control bits 0, 1, 2 and 5 always read 0. Bit 3 reads the reply attention flag, bit 4 the system-software attention flag, bit 6 host busy and bit 7 controller busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register offset of the host access |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe; a data-port read advances the outbound position at the clock edge |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational from `host_addr` |
| msg_req | output | 1 | One-cycle request to the controller to process the inbound message |
| in_len | output | CNT_W | Saturating count of inbound bytes written |
| ctl_in_idx | input | IDX_W | Controller read index into the inbound buffer |
| ctl_in_data | output | 8 | Inbound byte at `ctl_in_idx` |
| ctl_out_we | input | 1 | Controller write strobe into the outbound buffer |
| ctl_out_idx | input | IDX_W | Controller write index into the outbound buffer |
| ctl_out_data | input | 8 | Controller write byte |
| ctl_out_commit | input | 1 | Publishes the outbound reply |
| ctl_out_len | input | OLEN_W | Reply length sampled on commit |
| ctl_sms_set | input | 1 | Sets the system-software attention flag |

## Verification
Control writes are tried one bit at a time and in combinations. Single-bit writes separate the clear, toggle and launch semantics. A zero write shows that the clear bits need a one. Collisions with controller commits in the same cycle expose the set-versus-clear priority of the two flags that both sides touch. The inbound buffer is filled with random messages of random length, some shorter than DEPTH, some longer and one long enough to saturate the counter. These show the difference between storing, discarding and counting. Outbound replies of random length are drained, rewound, overread and committed with an oversized length, which separates in-order delivery, the end-of-message reset, the 0xFF idle value and the length clamp.

// File: rtl/bt_port_pkg.sv
package bt_port_pkg;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_MASK = 2'd2;

  localparam int BIT_CLR_IN  = 0;
  localparam int BIT_CLR_OUT = 1;
  localparam int BIT_LAUNCH  = 2;
  localparam int BIT_RPL_ATN = 3;
  localparam int BIT_SW_ATN  = 4;
  localparam int BIT_HOST_BSY = 6;
  localparam int BIT_CTL_BSY = 7;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef struct packed {
    logic ctl_bsy;
    logic host_bsy;
    logic sw_atn;
    logic rpl_atn;
  } flag_set_t;

  // Build the control byte seen by the host from the flag set.
  function automatic logic [7:0] pack_ctrl(input flag_set_t f);
    logic [7:0] b;
    b = 8'h00;
    b[BIT_CTL_BSY]  = f.ctl_bsy;
    b[BIT_HOST_BSY] = f.host_bsy;
    b[BIT_SW_ATN]   = f.sw_atn;
    b[BIT_RPL_ATN]  = f.rpl_atn;
    return b;
  endfunction

endpackage

// File: rtl/bt_flag_ctl.sv
module bt_flag_ctl
  import bt_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctrl_wr,
  input  logic      wr_launch,
  input  logic      wr_rpl_clr,
  input  logic      wr_sw_clr,
  input  logic      wr_hbsy_flip,
  input  logic      ctl_commit,
  input  logic      ctl_sms_set,
  output flag_set_t flags,
  output logic      msg_req
);

  logic launch_ev;
  logic rpl_clr_ev;
  logic sw_clr_ev;
  logic flip_ev;

  assign launch_ev  = ctrl_wr & wr_launch;
  assign rpl_clr_ev = ctrl_wr & wr_rpl_clr;
  assign sw_clr_ev  = ctrl_wr & wr_sw_clr;
  assign flip_ev    = ctrl_wr & wr_hbsy_flip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      msg_req <= 1'b0;
    end else begin
      msg_req <= launch_ev;
      // launch takes priority over a commit in the same cycle
      if (launch_ev)       flags.ctl_bsy <= 1'b1;
      else if (ctl_commit) flags.ctl_bsy <= 1'b0;
      // a controller set wins over a host clear
      if (ctl_commit)      flags.rpl_atn <= 1'b1;
      else if (rpl_clr_ev) flags.rpl_atn <= 1'b0;
      if (ctl_sms_set)     flags.sw_atn <= 1'b1;
      else if (sw_clr_ev)  flags.sw_atn <= 1'b0;
      if (flip_ev)         flags.host_bsy <= ~flags.host_bsy;
    end
  end

endmodule

// File: rtl/bt_in_buf.sv
module bt_in_buf #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic             clr_in,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] in_len,
  output logic             store_ev
);

  localparam logic [CNT_W-1:0] SAT_VAL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CAP     = CNT_W'(DEPTH);

  logic [7:0] mem [DEPTH];

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == SAT_VAL) ? v : v + CNT_W'(1);
  endfunction

  assign store_ev = data_wr && (in_len < CAP);
  assign rd_data  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (store_ev) mem[in_len[IDX_W-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       in_len <= '0;
    else if (clr_in)  in_len <= '0;
    else if (data_wr) in_len <= sat_inc(in_len);
  end

endmodule

// File: rtl/bt_out_buf.sv
module bt_out_buf #(
  parameter int DEPTH = 64,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int OLEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [IDX_W-1:0]  ctl_idx,
  input  logic [7:0]        ctl_data,
  input  logic              commit,
  input  logic [OLEN_W-1:0] commit_len,
  input  logic              pop,
  input  logic              clr_out,
  output logic [7:0]        head_byte,
  output logic              has_data,
  output logic [OLEN_W-1:0] out_pos,
  output logic [OLEN_W-1:0] out_len,
  output logic              drain_ev
);

  localparam logic [OLEN_W-1:0] CAP = OLEN_W'(DEPTH);

  logic [7:0]        mem [DEPTH];
  logic [OLEN_W-1:0] pos_nxt;
  logic              pop_ev;

  function automatic logic [OLEN_W-1:0] clamp_len(input logic [OLEN_W-1:0] l);
    return (l > CAP) ? CAP : l;
  endfunction

  assign has_data  = out_pos < out_len;
  assign head_byte = mem[out_pos[IDX_W-1:0]];
  assign pop_ev    = pop && has_data;
  assign pos_nxt   = out_pos + OLEN_W'(1);
  assign drain_ev  = pop_ev && (pos_nxt == out_len);

  always_ff @(posedge clk) begin
    if (ctl_we) mem[ctl_idx] <= ctl_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_pos <= '0;
      out_len <= '0;
    end else if (commit) begin
      out_pos <= '0;
      out_len <= clamp_len(commit_len);
    end else if (clr_out) begin
      out_pos <= '0;
    end else if (drain_ev) begin
      out_pos <= '0;
      out_len <= '0;
    end else if (pop_ev) begin
      out_pos <= pos_nxt;
    end
  end

endmodule

// File: rtl/bt_host_port.sv
module bt_host_port
  import bt_port_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int OLEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              msg_req,
  output logic [CNT_W-1:0]  in_len,
  input  logic [IDX_W-1:0]  ctl_in_idx,
  output logic [7:0]        ctl_in_data,
  input  logic              ctl_out_we,
  input  logic [IDX_W-1:0]  ctl_out_idx,
  input  logic [7:0]        ctl_out_data,
  input  logic              ctl_out_commit,
  input  logic [OLEN_W-1:0] ctl_out_len,
  input  logic              ctl_sms_set
);

  // decoded access events, named for the checker
  logic ctrl_wr;
  logic data_wr;
  logic data_rd;
  logic mask_wr;
  logic clr_in;
  logic clr_out;
  logic store_ev;
  logic drain_ev;
  logic has_data;

  flag_set_t         flags;
  logic [7:0]        mask_q;
  logic [7:0]        head_byte;
  logic [OLEN_W-1:0] out_pos;
  logic [OLEN_W-1:0] out_len;

  assign ctrl_wr = host_wr && (host_addr == OFS_CTRL);
  assign data_wr = host_wr && (host_addr == OFS_DATA);
  assign mask_wr = host_wr && (host_addr == OFS_MASK);
  assign data_rd = host_rd && (host_addr == OFS_DATA);
  assign clr_in  = ctrl_wr && host_wdata[BIT_CLR_IN];
  assign clr_out = ctrl_wr && host_wdata[BIT_CLR_OUT];

  bt_flag_ctl u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr      (ctrl_wr),
    .wr_launch    (host_wdata[BIT_LAUNCH]),
    .wr_rpl_clr   (host_wdata[BIT_RPL_ATN]),
    .wr_sw_clr    (host_wdata[BIT_SW_ATN]),
    .wr_hbsy_flip (host_wdata[BIT_HOST_BSY]),
    .ctl_commit   (ctl_out_commit),
    .ctl_sms_set  (ctl_sms_set),
    .flags        (flags),
    .msg_req      (msg_req)
  );

  bt_in_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_wr  (data_wr),
    .clr_in   (clr_in),
    .wdata    (host_wdata),
    .rd_idx   (ctl_in_idx),
    .rd_data  (ctl_in_data),
    .in_len   (in_len),
    .store_ev (store_ev)
  );

  bt_out_buf #(.DEPTH(DEPTH)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_out_we),
    .ctl_idx    (ctl_out_idx),
    .ctl_data   (ctl_out_data),
    .commit     (ctl_out_commit),
    .commit_len (ctl_out_len),
    .pop        (data_rd),
    .clr_out    (clr_out),
    .head_byte  (head_byte),
    .has_data   (has_data),
    .out_pos    (out_pos),
    .out_len    (out_len),
    .drain_ev   (drain_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= 8'h00;
    else if (mask_wr) mask_q <= host_wdata;
  end

  always_comb begin
    case (host_addr)
      OFS_CTRL: host_rdata = pack_ctrl(flags);
      OFS_DATA: host_rdata = has_data ? head_byte : IDLE_BYTE;
      OFS_MASK: host_rdata = mask_q;
      default:  host_rdata = IDLE_BYTE;
    endcase
  end

endmodule

// File: rtl/bt_host_port_chk.sv
module bt_host_port_chk #(
  parameter int CNT_W  = 8,
  parameter int OLEN_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_wr,
  input logic              data_wr,
  input logic              mask_wr,
  input logic              drain_ev,
  input logic              ctl_out_commit,
  input logic [1:0]        host_addr,
  input logic [7:0]        host_wdata,
  input logic [7:0]        host_rdata,
  input logic              msg_req,
  input logic              ctl_bsy,
  input logic              host_bsy,
  input logic [CNT_W-1:0]  in_len,
  input logic [OLEN_W-1:0] out_pos,
  input logic [OLEN_W-1:0] out_len,
  input logic [7:0]        mask_q
);

  localparam logic [CNT_W-1:0] SAT_VAL = {CNT_W{1'b1}};

  // R3
  launch_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && host_wdata[2] |=> msg_req && ctl_bsy);

  // R3
  req_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> $past(ctrl_wr && host_wdata[2]));

  // R5
  host_bsy_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && host_wdata[6] |=> host_bsy != $past(host_bsy));

  // R7
  in_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && in_len != SAT_VAL |=> in_len == $past(in_len) + CNT_W'(1));

  // R7
  in_count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && in_len == SAT_VAL |=> in_len == SAT_VAL);

  // R8
  drain_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ev && !ctl_out_commit |=> out_len == '0 && out_pos == '0);

  // R8
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_pos <= out_len);

  // R2
  idle_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == 2'd3 |-> host_rdata == 8'hFF);

  // R11
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask_q == $past(host_wdata));

endmodule

bind bt_host_port bt_host_port_chk #(.CNT_W(CNT_W), .OLEN_W(OLEN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctrl_wr        (ctrl_wr),
  .data_wr        (data_wr),
  .mask_wr        (mask_wr),
  .drain_ev       (drain_ev),
  .ctl_out_commit (ctl_out_commit),
  .host_addr      (host_addr),
  .host_wdata     (host_wdata),
  .host_rdata     (host_rdata),
  .msg_req        (msg_req),
  .ctl_bsy        (flags.ctl_bsy),
  .host_bsy       (flags.host_bsy),
  .in_len         (in_len),
  .out_pos        (out_pos),
  .out_len        (out_len),
  .mask_q         (mask_q)
);

// File: tb/bt_host_port_bench.sv
`timescale 1ns/1ps
module bt_host_port_bench;

  localparam int DEPTH  = 64;
  localparam int CNT_W  = 8;
  localparam int IDX_W  = 6;
  localparam int OLEN_W = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        host_addr = '0;
  logic              host_wr = 1'b0;
  logic              host_rd = 1'b0;
  logic [7:0]        host_wdata = '0;
  logic [7:0]        host_rdata;
  logic              msg_req;
  logic [CNT_W-1:0]  in_len;
  logic [IDX_W-1:0]  ctl_in_idx = '0;
  logic [7:0]        ctl_in_data;
  logic              ctl_out_we = 1'b0;
  logic [IDX_W-1:0]  ctl_out_idx = '0;
  logic [7:0]        ctl_out_data = '0;
  logic              ctl_out_commit = 1'b0;
  logic [OLEN_W-1:0] ctl_out_len = '0;
  logic              ctl_sms_set = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model of the flags
  logic m_cb = 0, m_hb = 0, m_sw = 0, m_ra = 0;
  logic [7:0] in_model [DEPTH];
  logic [7:0] out_model [DEPTH];

  always #2.5 clk = ~clk;

  bt_host_port u_bt_host_port (.*);

  function automatic logic [7:0] exp_ctrl(input logic cb, hb, sw, ra);
    return {cb, hb, 1'b0, sw, ra, 3'b000};
  endfunction

  function automatic int exp_count(input int writes);
    return (writes > 255) ? 255 : writes;
  endfunction

  function automatic int exp_clamp(input int l);
    return (l > DEPTH) ? DEPTH : l;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic peek_in(input int idx, output logic [7:0] d);
    ctl_in_idx = IDX_W'(idx);
    #0.5 d = ctl_in_data;
  endtask

  task automatic ctl_load(input int n, input int len_cmd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ctl_out_we = 1'b1; ctl_out_idx = IDX_W'(i); ctl_out_data = out_model[i];
    end
    @(negedge clk);
    ctl_out_we = 1'b0; ctl_out_commit = 1'b1; ctl_out_len = OLEN_W'(len_cmd);
    @(negedge clk);
    ctl_out_commit = 1'b0;
    m_ra = 1'b1; m_cb = 1'b0;
  endtask

  task automatic check_ctrl(input string req);
    logic [7:0] d;
    host_read(2'd0, d);
    check(req, 32'(d), 32'(exp_ctrl(m_cb, m_hb, m_sw, m_ra)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 msg_req", 32'(msg_req), 0);
    check("R1 in_len", 32'(in_len), 0);
    check_ctrl("R1 ctrl");
    host_read(2'd2, d); check("R1 mask", 32'(d), 0);
    host_read(2'd1, d); check("R1 data idle", 32'(d), 32'hFF);

    // R2 undecoded offset
    host_read(2'd3, d); check("R2 offset3 read", 32'(d), 32'hFF);
    host_write(2'd3, 8'hFF);
    check_ctrl("R2 ctrl untouched");
    host_read(2'd2, d); check("R2 mask untouched", 32'(d), 0);

    // R11 mask register
    host_write(2'd2, 8'hA5);
    host_read(2'd2, d); check("R11 mask A5", 32'(d), 32'hA5);
    host_write(2'd2, 8'h3C);
    host_read(2'd2, d); check("R11 mask 3C", 32'(d), 32'h3C);

    // R3 launch: pulse right after the accepting edge, gone one cycle later
    host_write(2'd0, 8'h04);
    m_cb = 1'b1;
    check("R3 msg_req high", 32'(msg_req), 1);
    @(negedge clk);
    check("R3 msg_req one cycle", 32'(msg_req), 0);
    check_ctrl("R3 ctrl busy");

    // R5 host busy toggle, R12 layout
    host_write(2'd0, 8'h40); m_hb = 1'b1;
    check_ctrl("R5 toggle on");
    host_write(2'd0, 8'h00);
    check_ctrl("R5 zero no change");
    host_write(2'd0, 8'h40); m_hb = 1'b0;
    check_ctrl("R5 toggle off");
    host_write(2'd0, 8'h27); m_cb = 1'b1;
    check_ctrl("R12 bits 0 1 2 5 read zero");

    // R10 / R4 system-software attention
    @(negedge clk); ctl_sms_set = 1'b1;
    @(negedge clk); ctl_sms_set = 1'b0; m_sw = 1'b1;
    check_ctrl("R10 sms set");
    host_write(2'd0, 8'h00);
    check_ctrl("R4 zero keeps sms");
    host_write(2'd0, 8'h10); m_sw = 1'b0;
    check_ctrl("R4 clear sms");

    // R9 commit clears controller busy and raises reply attention
    for (int i = 0; i < 3; i++) out_model[i] = 8'(8'h10 + i);
    ctl_load(3, 3);
    check_ctrl("R9 commit flags");
    host_write(2'd0, 8'h00);
    check_ctrl("R4 zero keeps reply atn");

    // R6 rewind of outbound position
    host_read(2'd1, d); check("R8 byte0", 32'(d), 32'h10);
    host_read(2'd1, d); check("R8 byte1", 32'(d), 32'h11);
    host_write(2'd0, 8'h02);
    host_read(2'd1, d); check("R6 rewind byte0", 32'(d), 32'h10);
    host_read(2'd1, d); check("R6 rewind byte1", 32'(d), 32'h11);
    host_read(2'd1, d); check("R8 last", 32'(d), 32'h12);
    host_read(2'd1, d); check("R8 empty after drain", 32'(d), 32'hFF);
    host_write(2'd0, 8'h02);
    host_read(2'd1, d); check("R8 length zeroed after drain", 32'(d), 32'hFF);
    host_write(2'd0, 8'h08); m_ra = 1'b0;
    check_ctrl("R4 clear reply atn");

    // R4 / R9 collision: commit together with clear-attention and launch
    @(negedge clk);
    ctl_out_commit = 1'b1; ctl_out_len = OLEN_W'(0);
    host_addr = 2'd0; host_wdata = 8'h0C; host_wr = 1'b1;
    @(negedge clk);
    ctl_out_commit = 1'b0; host_wr = 1'b0;
    m_ra = 1'b1; m_cb = 1'b1;
    check("R3 req on collision", 32'(msg_req), 1);
    check_ctrl("R4 R9 set wins, launch keeps busy");
    host_write(2'd0, 8'h08); m_ra = 1'b0;

    // R7 random inbound messages, some overrunning the buffer
    for (int t = 0; t < 6; t++) begin
      host_write(2'd0, 8'h01);
      check(("R6 clear in_len"), 32'(in_len), 0);
      n = 1 + int'($urandom_range(0, 79));
      if (t == 0) n = DEPTH;
      for (int i = 0; i < n; i++) begin
        d = 8'($urandom);
        if (i < DEPTH) in_model[i] = d;
        host_write(2'd1, d);
      end
      check("R7 in_len count", 32'(in_len), 32'(exp_count(n)));
      for (int i = 0; i < ((n < DEPTH) ? n : DEPTH); i++) begin
        peek_in(i, d);
        check("R7 stored byte", 32'(d), 32'(in_model[i]));
      end
    end

    // R7 saturation with discard past DEPTH
    host_write(2'd0, 8'h01);
    for (int i = 0; i < 260; i++) begin
      d = 8'(i * 7 + 3);
      if (i < DEPTH) in_model[i] = d;
      host_write(2'd1, d);
    end
    check("R7 saturate", 32'(in_len), 32'(exp_count(260)));
    peek_in(0, d);  check("R7 first kept", 32'(d), 32'(in_model[0]));
    peek_in(63, d); check("R7 last kept", 32'(d), 32'(in_model[63]));

    // R8 random outbound replies
    for (int t = 0; t < 5; t++) begin
      n = 1 + int'($urandom_range(0, DEPTH - 1));
      for (int i = 0; i < n; i++) out_model[i] = 8'($urandom);
      ctl_load(n, n);
      for (int i = 0; i < n; i++) begin
        host_read(2'd1, d);
        check("R8 reply byte", 32'(d), 32'(out_model[i]));
      end
      host_read(2'd1, d); check("R8 overread", 32'(d), 32'hFF);
      host_write(2'd0, 8'h08); m_ra = 1'b0;
    end

    // R9 oversized commit length is clamped
    for (int i = 0; i < DEPTH; i++) out_model[i] = 8'(255 - i);
    ctl_load(DEPTH, 70);
    for (int i = 0; i < exp_clamp(70); i++) begin
      host_read(2'd1, d);
      check("R9 clamped reply byte", 32'(d), 32'(out_model[i]));
    end
    host_read(2'd1, d); check("R9 clamp end", 32'(d), 32'hFF);

    summary();
    $finish;
  end

endmodule